// File: doc/BRIEF.md
# PCI Interrupt and Error Aggregator

This block gathers the interrupt sources of a PCI host bridge and hands them to a system interrupt controller. Its inputs are the four active-low INTx lines, which arrive from the bus asynchronously, and single-cycle event pulses from the DMA engine and the bus error detectors. The INTx lines are synchronised and shown as raw levels, read back inverted so that a zero means asserted. The events are caught in sticky flags, and software clears each flag by writing a one to its bit.

A 2-bit strap selects the output topology. In the two shared modes every enabled source is ORed onto one level interrupt. In the two split modes each INTx line drives its own output, and error interrupts ride on the first line's output. An odd mode sends the DMA flags to a dedicated DMA output. An even mode merges them into the shared output, or into the first line's output. A control word holds the per-line enables, the error interrupt enables, two error-response bits that are stored only, and the PCI bus reset.

Software reaches the control and status words through a one-bit select. A write takes effect on the next clock. Reads are combinational.

Top module: `pirq_hub`

## Requirements
- R1: After synchronous reset the control word reads 0, all six sticky flags read 0, the level field (status bits 11:8) reads 4'hF while the INTx inputs are high, and irq_shared_o, irq_line_o, irq_dma_o and bus_rst_o are 0.
- R2: A write with reg_sel_i=0 stores control bits 31, 27:24 and 3:0. Those bits read back, and every other control bit reads 0. bus_rst_o equals stored control bit 31.
- R3: Status bits 11:8 show INTx lines D..A (bit 8 = line A) after a two-flop synchroniser, so a low level is read as 0. An input change appears at the outputs two clock edges after it is applied.
- R4: A line is pending when its synchronised level is 0 and its enable (control bit 0 = line A … bit 3 = line D) is 1. A low line whose enable is 0 affects no output.
- R5: A one-cycle pulse sets a sticky status flag. The flags sit at these positions: system error at bit 17, DMA done at 16, DMA error at 15, master abort at 14, target abort at 13, parity error at 12.
- R6: Writing status (reg_sel_i=1) with a one in a flag position clears that flag, and a zero leaves it unchanged. A pulse in the same cycle as the clearing write leaves the flag set.
- R7: Master abort, target abort and parity flags raise an interrupt only when control bit 25 is 1. The system error flag does so only when control bit 27 is 1. Control bits 24 and 26 have no effect on any output.
- R8: Status bits 25:24 read the current irq_mode_i value. All other status bits outside 25:24, 17:12 and 11:8 read 0.
- R9: In modes 0 and 1, irq_shared_o is the OR of the pending lines and the enabled error flags, and irq_line_o is 0.
- R10: In modes 2 and 3, irq_line_o[i] reflects pending line i, irq_line_o[0] also carries the enabled error flags, and irq_shared_o is 0.
- R11: In odd modes, irq_dma_o is the OR of the DMA done and DMA error flags, and these flags reach no other output. In even modes irq_dma_o is 0, and the DMA flags join irq_shared_o in mode 0 or irq_line_o[0] in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_mode_i | input | 2 | Interrupt topology strap |
| intx_n_i | input | 4 | Asynchronous active-low INTx lines, bit 0 = line A |
| dma_done_i | input | 1 | DMA completion pulse |
| dma_err_i | input | 1 | DMA error pulse |
| sys_err_i | input | 1 | System error pulse |
| mst_abort_i | input | 1 | Master abort pulse |
| tgt_abort_i | input | 1 | Target abort pulse |
| par_err_i | input | 1 | Parity error pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control, 1 selects status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| irq_shared_o | output | 1 | Shared level interrupt (modes 0, 1) |
| irq_line_o | output | 4 | Per-line level interrupts (modes 2, 3) |
| irq_dma_o | output | 1 | Dedicated DMA interrupt (odd modes) |
| bus_rst_o | output | 1 | PCI bus reset request |

## Verification
Within one clock, an event pulse can meet a software write that clears the same sticky flag, and the two race for that flag. The bench drives a DMA-done pulse on the very edge at which a status write clears both DMA flags. It then reads status and expects DMA done still set and DMA error gone. The same read shows that the clear and the set acted on separate bits in the same cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int REG_W   = 32;
    localparam int LINES   = 4;
    localparam int EVT_N   = 6;

    // control bit positions
    localparam int CB_BUSRST = 31;
    localparam int CB_SYSIE  = 27;
    localparam int CB_PAREN  = 26;
    localparam int CB_ERRIE  = 25;
    localparam int CB_ERRRSP = 24;

    // status field positions
    localparam int SB_MODE   = 24;
    localparam int SB_EVT    = 12;
    localparam int SB_LVL    = 8;

    typedef enum logic [1:0] {
        MODE_SHARED     = 2'd0,
        MODE_SHARED_DMA = 2'd1,
        MODE_SPLIT      = 2'd2,
        MODE_SPLIT_DMA  = 2'd3
    } mode_e;

    // packed so that bit 5 lands on status 17 and bit 0 on status 12
    typedef struct packed {
        logic sys;
        logic ddone;
        logic derr;
        logic mabt;
        logic tabt;
        logic par;
    } evt_t;

    typedef struct packed {
        logic             bus_rst;
        logic             sys_ie;
        logic             par_en;
        logic             err_ie;
        logic             err_rsp;
        logic [LINES-1:0] line_en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CB_BUSRST]   = c.bus_rst;
        w[CB_SYSIE]    = c.sys_ie;
        w[CB_PAREN]    = c.par_en;
        w[CB_ERRIE]    = c.err_ie;
        w[CB_ERRRSP]   = c.err_rsp;
        w[LINES-1:0]   = c.line_en;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.bus_rst = w[CB_BUSRST];
        c.sys_ie  = w[CB_SYSIE];
        c.par_en  = w[CB_PAREN];
        c.err_ie  = w[CB_ERRIE];
        c.err_rsp = w[CB_ERRRSP];
        c.line_en = w[LINES-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic [1:0] mode,
                                                     input evt_t flags,
                                                     input logic [LINES-1:0] lvl_n);
        logic [REG_W-1:0] w;
        w = '0;
        w[SB_MODE +: 2]     = mode;
        w[SB_EVT +: EVT_N]  = flags;
        w[SB_LVL +: LINES]  = lvl_n;
        return w;
    endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [REG_W-1:0] wdata_i,
    input  evt_t             evt_i,
    output ctrl_t            ctrl_o,
    output evt_t             flags_o
);
    ctrl_t             ctrl_q;
    logic [EVT_N-1:0]  flag_q;
    logic [EVT_N-1:0]  clr_mask;
    logic              unused_wbits;

    assign clr_mask = (wr_i && sel_i) ? wdata_i[SB_EVT +: EVT_N] : '0;
    assign unused_wbits = ^{wdata_i[30:28], wdata_i[23:18], wdata_i[11:4]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= '0;
        end else begin
            if (wr_i && !sel_i) ctrl_q <= word_to_ctrl(wdata_i);
            // a pulse arriving with the clear keeps its flag
            flag_q <= (flag_q & ~clr_mask) | evt_i;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign flags_o = evt_t'(flag_q);

    // R5
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i && evt_i == '0) |=> ((flag_q & $past(wdata_i[SB_EVT +: EVT_N])) == '0));

    // R2
    bus_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !sel_i) |=> (ctrl_q.bus_rst == $past(wdata_i[CB_BUSRST])));
endmodule

// File: rtl/pirq_route.sv
module pirq_route
    import pirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [LINES-1:0] line_en_i,
    input  logic             err_ie_i,
    input  logic             sys_ie_i,
    input  evt_t             flags_i,
    input  logic [LINES-1:0] lvl_n_i,
    output logic             shared_o,
    output logic [LINES-1:0] line_o,
    output logic             dma_o
);
    logic [LINES-1:0] pend;
    logic             err_irq, dma_irq, dma_sep, split, merged_extra;

    assign pend     = ~lvl_n_i & line_en_i;
    assign err_irq  = (err_ie_i & (flags_i.mabt | flags_i.tabt | flags_i.par))
                    | (sys_ie_i & flags_i.sys);
    assign dma_irq  = flags_i.ddone | flags_i.derr;
    assign dma_sep  = mode_i[0];
    assign split    = mode_i[1];
    assign merged_extra = err_irq | (dma_irq & ~dma_sep);

    always_comb begin
        shared_o = 1'b0;
        line_o   = '0;
        if (split) begin
            line_o    = pend;
            line_o[0] = pend[0] | merged_extra;
        end else begin
            shared_o  = (|pend) | merged_extra;
        end
    end

    assign dma_o = dma_sep & dma_irq;

    // R11
    dma_even_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_i[0] |-> !dma_o);

    // R10
    split_no_shared_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i[1] |-> !shared_o);

    // R9
    shared_no_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_i[1] |-> (line_o == '0));

    // R7
    err_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SHARED_DMA && !err_ie_i && !sys_ie_i && lvl_n_i == '1) |-> !shared_o);
endmodule

// File: rtl/pirq_hub.sv
module pirq_hub
    import pirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       irq_mode_i,
    input  logic [3:0]       intx_n_i,
    input  logic             dma_done_i,
    input  logic             dma_err_i,
    input  logic             sys_err_i,
    input  logic             mst_abort_i,
    input  logic             tgt_abort_i,
    input  logic             par_err_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [31:0]      reg_wdata_i,
    output logic [31:0]      reg_rdata_o,
    output logic             irq_shared_o,
    output logic [3:0]       irq_line_o,
    output logic             irq_dma_o,
    output logic             bus_rst_o
);
    logic [LINES-1:0] lvl_n;
    ctrl_t            ctrl;
    evt_t             flags;
    evt_t             evt_in;

    assign evt_in = '{sys:   sys_err_i,
                      ddone: dma_done_i,
                      derr:  dma_err_i,
                      mabt:  mst_abort_i,
                      tabt:  tgt_abort_i,
                      par:   par_err_i};

    pirq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL({LINES{1'b1}})) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (intx_n_i),
        .q_o (lvl_n)
    );

    pirq_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .evt_i   (evt_in),
        .ctrl_o  (ctrl),
        .flags_o (flags)
    );

    pirq_route route_i (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (irq_mode_i),
        .line_en_i (ctrl.line_en),
        .err_ie_i  (ctrl.err_ie),
        .sys_ie_i  (ctrl.sys_ie),
        .flags_i   (flags),
        .lvl_n_i   (lvl_n),
        .shared_o  (irq_shared_o),
        .line_o    (irq_line_o),
        .dma_o     (irq_dma_o)
    );

    assign reg_rdata_o = reg_sel_i ? status_word(irq_mode_i, flags, lvl_n)
                                   : ctrl_to_word(ctrl);
    assign bus_rst_o   = ctrl.bus_rst;
endmodule

// File: tb/pirq_hub_tb.sv
`timescale 1ns/1ps
module pirq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  irq_mode = 2'd0;
    logic [3:0]  intx_n = 4'hF;
    logic        dma_done = 0, dma_err = 0, sys_err = 0, mst_abort = 0, tgt_abort = 0, par_err = 0;
    logic        reg_wr = 0, reg_sel = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_shared, irq_dma, bus_rst;
    logic [3:0]  irq_line;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pirq_hub dut_i (
        .clk(clk), .rst(rst), .irq_mode_i(irq_mode), .intx_n_i(intx_n),
        .dma_done_i(dma_done), .dma_err_i(dma_err), .sys_err_i(sys_err),
        .mst_abort_i(mst_abort), .tgt_abort_i(tgt_abort), .par_err_i(par_err),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_shared_o(irq_shared), .irq_line_o(irq_line),
        .irq_dma_o(irq_dma), .bus_rst_o(bus_rst)
    );

    // fields: mode[15:14] en[13:10] lines_n[9:6] shared[5] line_out[4:1] dma[0]
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 4'hF, 4'hE, 1'b1, 4'h0, 1'b0},
        {2'd0, 4'hE, 4'hE, 1'b0, 4'h0, 1'b0},
        {2'd1, 4'h8, 4'h7, 1'b1, 4'h0, 1'b0},
        {2'd2, 4'hF, 4'h5, 1'b0, 4'hA, 1'b0},
        {2'd3, 4'h3, 4'h0, 1'b0, 4'h3, 1'b0},
        {2'd2, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic outs(input string req, input logic s, input logic [3:0] l, input logic dm);
        chk(req, {29'd0, irq_shared, irq_line[3] , irq_dma}, {29'd0, s, l[3], dm});
        chk(req, {28'd0, irq_line}, {28'd0, l});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, d); chk("R1 ctrl", d, 32'h0);
        rd(1'b1, d); chk("R1 status", d, 32'h0000_0F00);
        outs("R1 outputs", 1'b0, 4'h0, 1'b0);
        chk("R1 bus_rst", {31'd0, bus_rst}, 32'd0);

        // R2 control storage and bus reset
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); chk("R2 ctrl readback", d, 32'h8F00_000F);
        chk("R2 bus_rst", {31'd0, bus_rst}, 32'd1);
        wr(1'b0, 32'h0);
        chk("R2 bus_rst off", {31'd0, bus_rst}, 32'd0);

        // table: R3 R4 R9 R10 routing of lines
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            irq_mode = VEC[i][15:14];
            intx_n   = VEC[i][9:6];
            wr(1'b0, {28'd0, VEC[i][13:10]});
            repeat (3) @(negedge clk);
            outs($sformatf("R4 R9 R10 vec%0d", i), VEC[i][5], VEC[i][4:1], VEC[i][0]);
            rd(1'b1, d);
            chk($sformatf("R3 level vec%0d", i), {28'd0, d[11:8]}, {28'd0, VEC[i][9:6]});
        end

        // back to quiet lines
        @(negedge clk); intx_n = 4'hF; irq_mode = 2'd1;
        wr(1'b0, 32'h0);
        repeat (3) @(negedge clk);

        // R5 pulse all events once
        dma_done = 1; dma_err = 1; sys_err = 1; mst_abort = 1; tgt_abort = 1; par_err = 1;
        @(negedge clk);
        dma_done = 0; dma_err = 0; sys_err = 0; mst_abort = 0; tgt_abort = 0; par_err = 0;
        rd(1'b1, d); chk("R5 R8 sticky flags", d, 32'h0103_FF00);
        outs("R11 odd mode dma only", 1'b0, 4'h0, 1'b1);

        // R7 enables
        wr(1'b0, 32'h0500_0000);
        outs("R7 bits 24 26 no effect", 1'b0, 4'h0, 1'b1);
        wr(1'b0, 32'h0200_0000);
        outs("R7 err enable", 1'b1, 4'h0, 1'b1);
        wr(1'b1, 32'h0000_7000);
        outs("R7 sys flag needs bit 27", 1'b0, 4'h0, 1'b1);
        rd(1'b1, d); chk("R6 partial clear", d[17:12], 6'b11_1000);
        wr(1'b0, 32'h0800_0000);
        outs("R7 sys enable", 1'b1, 4'h0, 1'b1);
        wr(1'b1, 32'h0002_0000);
        wr(1'b0, 32'h0);

        // R11 DMA routing by mode
        @(negedge clk); irq_mode = 2'd0; #1;
        outs("R11 mode0 dma shared", 1'b1, 4'h0, 1'b0);
        irq_mode = 2'd2; #1;
        outs("R11 mode2 dma on line0", 1'b0, 4'h1, 1'b0);
        irq_mode = 2'd3; #1;
        outs("R11 mode3 dma separate", 1'b0, 4'h0, 1'b1);
        rd(1'b1, d); chk("R8 mode field", {30'd0, d[25:24]}, 32'd3);

        // R6 zero write keeps flags
        wr(1'b1, 32'h0);
        rd(1'b1, d); chk("R6 zero write", d[17:12], 6'b01_1000);

        // R6 set beats clear in the same cycle
        @(negedge clk);
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0001_8000; dma_done = 1;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; dma_done = 0;
        rd(1'b1, d); chk("R6 collision", d[17:12], 6'b01_0000);
        wr(1'b1, 32'h0001_0000);
        rd(1'b1, d); chk("R6 final clear", d[17:12], 6'b00_0000);

        // R3 two-edge latency, R4 enable gating
        @(negedge clk); irq_mode = 2'd0;
        wr(1'b0, 32'h0000_0004);
        @(negedge clk); intx_n = 4'b1011;
        @(negedge clk);
        chk("R3 after one edge", {31'd0, irq_shared}, 32'd0);
        @(negedge clk);
        chk("R3 after two edges", {31'd0, irq_shared}, 32'd1);
        intx_n = 4'b0111;
        repeat (3) @(negedge clk);
        chk("R4 disabled line ignored", {31'd0, irq_shared}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule